// File: doc/BRIEF.md
# Push-Only Clock-Crossing Sample FIFO

This block carries fixed-width samples from a source clock domain into an unrelated destination clock domain. The producer offers a sample with a valid strobe and gets no ready signal back. The storage is a small dual-clock RAM. Its write and read positions are kept as Gray-coded counters, and each counter reaches the other domain through a two-stage flop chain.

The destination side needs no request input. While anything is stored, it takes one entry on every destination clock, puts the entry on a registered data output, and raises a valid strobe for that cycle only. A producer that runs faster than the consumer will eventually find the buffer full. In that case the offered sample is thrown away and an overrun strobe is raised for one source cycle.

The two domains have separate active-low resets. This allows the reading side to be held in reset while the writing side fills the storage.

Top module: `cdc_push_fifo`

## Requirements
- R1: While `srcRstN` is low, `overrun` is 0. While `dstRstN` is low, `dstValid` is 0 and `dstData` is all zeros.
- R2: Every accepted sample appears on `dstData` exactly once, unaltered and in the order it was written.
- R3: `dstValid` is high for one destination cycle per stored entry. With N entries stored, the side drains them on N consecutive destination cycles without any request input, and the cycle after a single entry shows `dstValid` low.
- R4: The buffer holds DEPTH entries. With the destination held in reset, exactly DEPTH consecutive offers are accepted. Later offers leave the write position unchanged.
- R5: `overrun` is high during the source cycle that follows a rising `srcClk` edge at which `srcValid` was high and the buffer was full. It is low at all other times, and a dropped sample is never delivered.
- R6: After reset, `dstValid` stays low until at least one sample has been accepted.
- R7: A lone sample written into an empty buffer raises `dstValid` no later than the fourth rising `dstClk` edge after the `srcClk` edge that accepted it. The path is two synchronizer stages plus one output register.
- R8: The write and read positions are Gray-coded counters, each one bit wider than the address. At every edge of its own clock, each changes in at most one bit, and each is passed to the opposite domain through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain reset, active low, asynchronous assert |
| srcData | input | WIDTH | Sample offered by the producer |
| srcValid | input | 1 | Offer strobe, sampled on each rising `srcClk` |
| overrun | output | 1 | One-cycle strobe: the previous offer was dropped |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain reset, active low, asynchronous assert |
| dstData | output | WIDTH | Registered sample output |
| dstValid | output | 1 | One-cycle strobe qualifying `dstData` |

## Verification
An overrun drop and a drain-side pop can fall in the same period. The destination may free a slot at the very moment an offer arrives, but the source still sees the stale, synchronized read position and drops the offer. This case is provoked by a long back-to-back burst: the source runs at 10 ns and the destination at 13 ns, so the buffer sits at its full boundary while it is also being emptied. It is judged by the scoreboard. Only offers not followed by `overrun` enter the expected queue, and every destination strobe must match the queue head. A dropped sample that leaked through, or an accepted sample that was lost, therefore shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

  // Per-cycle strobes from the two control halves to the storage.
  typedef struct packed {
    logic wrEn;   // source domain: store srcData at wrAddr
    logic rdEn;   // destination domain: load dstData from rdAddr
  } pfifoStrobe_t;

endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pfifo_src_ctl.sv
module pfifo_src_ctl #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          srcValid,
  input  logic [PW-1:0] rdGraySync,
  output logic          wrEn,
  output logic [AW-1:0] wrAddr,
  output logic [PW-1:0] wrGray,
  output logic          overrun
);

  // A full buffer differs from the read position only in the two top Gray bits.
  localparam logic [PW-1:0] FULL_MASK = PW'(3) << (AW - 1);

  logic [PW-1:0] wrBin;
  logic [PW-1:0] wrBinNext;
  logic          full;

  assign full      = (wrGray == (rdGraySync ^ FULL_MASK));
  assign wrEn      = srcValid && !full;
  assign wrBinNext = wrBin + {{AW{1'b0}}, wrEn};
  assign wrAddr    = wrBin[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      overrun <= 1'b0;
    end else begin
      wrBin   <= wrBinNext;
      wrGray  <= wrBinNext ^ (wrBinNext >> 1);
      overrun <= srcValid && full;
    end
  end

endmodule

// File: rtl/pfifo_dst_ctl.sv
module pfifo_dst_ctl #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] wrGraySync,
  output logic          rdEn,
  output logic [AW-1:0] rdAddr,
  output logic [PW-1:0] rdGray,
  output logic          dstValid
);

  logic [PW-1:0] rdBin;
  logic [PW-1:0] rdBinNext;

  // Drain automatically whenever the synchronized write position is ahead.
  assign rdEn      = (rdGray != wrGraySync);
  assign rdBinNext = rdBin + {{AW{1'b0}}, rdEn};
  assign rdAddr    = rdBin[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      dstValid <= 1'b0;
    end else begin
      rdBin    <= rdBinNext;
      rdGray   <= rdBinNext ^ (rdBinNext >> 1);
      dstValid <= rdEn;
    end
  end

endmodule

// File: rtl/pfifo_store.sv
module pfifo_store
  import pfifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             srcClk,
  input  logic             dstClk,
  input  logic             dstRstN,
  input  pfifoStrobe_t     strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] dstData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge srcClk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN)         dstData <= '0;
    else if (strobe.rdEn) dstData <= mem[rdAddr];
  end

endmodule

// File: rtl/cdc_push_fifo.sv
module cdc_push_fifo
  import pfifo_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic             srcClk,
  input  logic             srcRstN,
  input  logic [WIDTH-1:0] srcData,
  input  logic             srcValid,
  output logic             overrun,
  input  logic             dstClk,
  input  logic             dstRstN,
  output logic [WIDTH-1:0] dstData,
  output logic             dstValid
);

  pfifoStrobe_t  strobe;
  logic          wrEn;
  logic          rdEn;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  logic [PW-1:0] wrGray;
  logic [PW-1:0] rdGray;
  logic [PW-1:0] wrGraySync;
  logic [PW-1:0] rdGraySync;

  assign strobe.wrEn = wrEn;
  assign strobe.rdEn = rdEn;

  pfifo_src_ctl #(.AW(AW)) uSrcCtl (
    .clk(srcClk), .rstN(srcRstN), .srcValid(srcValid),
    .rdGraySync(rdGraySync), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrGray(wrGray), .overrun(overrun)
  );

  pfifo_dst_ctl #(.AW(AW)) uDstCtl (
    .clk(dstClk), .rstN(dstRstN), .wrGraySync(wrGraySync),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdGray(rdGray), .dstValid(dstValid)
  );

  pfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) uWrToDst (
    .clk(dstClk), .rstN(dstRstN), .d(wrGray), .q(wrGraySync)
  );

  pfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) uRdToSrc (
    .clk(srcClk), .rstN(srcRstN), .d(rdGray), .q(rdGraySync)
  );

  pfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uStore (
    .srcClk(srcClk), .dstClk(dstClk), .dstRstN(dstRstN),
    .strobe(strobe), .wrAddr(wrAddr), .wrData(srcData),
    .rdAddr(rdAddr), .dstData(dstData)
  );

endmodule

// File: rtl/pfifo_chk.sv
module pfifo_chk #(
  parameter int PW = 5
) (
  input logic          srcClk,
  input logic          srcRstN,
  input logic          dstClk,
  input logic          dstRstN,
  input logic          srcValid,
  input logic          overrun,
  input logic          dstValid,
  input logic [PW-1:0] wrGray,
  input logic [PW-1:0] rdGray
);

  // R8: Gray write position moves by at most one bit per source edge
  p_wr_gray_step_r8: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // R8: Gray read position moves by at most one bit per destination edge
  p_rd_gray_step_r8: assert property (@(posedge dstClk) disable iff (!dstRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);

  // R5: an overrun strobe always follows an offer
  p_overrun_cause_r5: assert property (@(posedge srcClk) disable iff (!srcRstN)
    overrun |-> $past(srcValid));

  // R4: a dropped offer leaves the write position untouched
  p_overrun_drop_r4: assert property (@(posedge srcClk) disable iff (!srcRstN)
    overrun |-> $stable(wrGray));

  // R3: each output strobe corresponds to exactly one read-position step
  p_valid_pops_r3: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstValid |-> ($countones(rdGray ^ $past(rdGray)) == 1));

endmodule

bind cdc_push_fifo pfifo_chk #(.PW(PW)) uChk (
  .srcClk(srcClk), .srcRstN(srcRstN), .dstClk(dstClk), .dstRstN(dstRstN),
  .srcValid(srcValid), .overrun(overrun), .dstValid(dstValid),
  .wrGray(wrGray), .rdGray(rdGray)
);

// File: tb/test_cdc_push_fifo.sv
module test_cdc_push_fifo;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WIDTH = 8;
  localparam int DEPTH = 16;

  logic             srcClk = 1'b0;
  logic             dstClk = 1'b0;
  logic             srcRstN = 1'b0;
  logic             dstRstN = 1'b0;
  logic [WIDTH-1:0] srcData = '0;
  logic             srcValid = 1'b0;
  logic             overrun;
  logic [WIDTH-1:0] dstData;
  logic             dstValid;

  always #5   srcClk = ~srcClk;   // 100 MHz source
  always #6.5 dstClk = ~dstClk;   // unrelated, slower destination

  cdc_push_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_cdc_push_fifo (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcData(srcData), .srcValid(srcValid),
    .overrun(overrun), .dstClk(dstClk), .dstRstN(dstRstN),
    .dstData(dstData), .dstValid(dstValid)
  );

  int total = 0;
  int bad = 0;
  int accepted = 0;
  int dropped = 0;
  int delivered = 0;
  bit sawValid = 1'b0;
  bit finished = 1'b0;
  realtime lastValidTime = 0;
  logic [WIDTH-1:0] expQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $realtime);
    end
  endtask

  // Source-side monitor: the offer seen at an edge is judged by overrun after it.
  logic             attD1 = 1'b0;
  logic [WIDTH-1:0] datD1 = '0;
  always @(posedge srcClk) begin
    attD1 <= srcValid && srcRstN;
    datD1 <= srcData;
  end
  always @(negedge srcClk) begin
    if (srcRstN) begin
      if (overrun && !attD1) check(1'b0, "R5 overrun without offer", 1, 0);
      if (attD1) begin
        if (overrun) dropped++;
        else begin
          expQ.push_back(datD1);
          accepted++;
        end
      end
    end
  end

  // Destination-side monitor: compare against the scoreboard head.
  always @(negedge dstClk) begin
    if (dstRstN && dstValid) begin
      sawValid = 1'b1;
      lastValidTime = $realtime;
      if (expQ.size() == 0) check(1'b0, "R6 strobe with nothing accepted", int'(dstData), -1);
      else begin
        logic [WIDTH-1:0] e;
        e = expQ.pop_front();
        check(dstData == e, "R2 data/order", int'(dstData), int'(e));
        delivered++;
      end
    end
  end

  task automatic push(input logic [WIDTH-1:0] d);
    srcData  = d;
    srcValid = 1'b1;
    @(posedge srcClk);
    #1 srcValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int accBase;
    int dropBase;
    int run;
    realtime tWrite;
    logic [15:0] lfsr;

    // Reset state (R1)
    repeat (4) @(negedge srcClk);
    check(overrun == 1'b0, "R1 overrun in reset", int'(overrun), 0);
    check(dstValid == 1'b0, "R1 dstValid in reset", int'(dstValid), 0);
    check(dstData == '0, "R1 dstData in reset", int'(dstData), 0);

    // No strobe before the first accepted write (R6)
    srcRstN = 1'b1;
    dstRstN = 1'b1;
    repeat (30) @(negedge dstClk);
    check(!sawValid, "R6 idle strobe", int'(sawValid), 0);

    // Lone write latency and single-cycle strobe (R7, R3)
    @(negedge srcClk);
    srcData  = 8'hA5;
    srcValid = 1'b1;
    @(posedge srcClk);
    tWrite = $realtime;
    #1 srcValid = 1'b0;
    repeat (8) @(negedge dstClk);
    check(sawValid, "R7 lone write delivered", int'(sawValid), 1);
    check((lastValidTime - tWrite) <= 58.5, "R7 latency ns",
          int'(lastValidTime - tWrite), 58);
    check(dstValid == 1'b0, "R3 single strobe per entry", int'(dstValid), 0);

    // Full boundary with reader held in reset (R4, R5)
    @(negedge srcClk);
    srcRstN = 1'b0;
    dstRstN = 1'b0;
    repeat (4) @(negedge srcClk);
    srcRstN = 1'b1;
    repeat (4) @(negedge srcClk);
    accBase  = accepted;
    dropBase = dropped;
    for (int i = 0; i < DEPTH + 4; i++) push(WIDTH'(8'h40 + i));
    repeat (3) @(negedge srcClk);
    check(accepted - accBase == DEPTH, "R4 entries accepted when full",
          accepted - accBase, DEPTH);
    check(dropped - dropBase == 4, "R5 overrun count at full", dropped - dropBase, 4);
    check(dstValid == 1'b0, "R1 reader held in reset", int'(dstValid), 0);

    // Release reader: back-to-back drain (R3)
    @(negedge dstClk);
    dstRstN = 1'b1;
    run = 0;
    for (int i = 0; i < 20 && !dstValid; i++) @(negedge dstClk);
    while (dstValid) begin
      run++;
      @(negedge dstClk);
    end
    check(run == DEPTH, "R3 consecutive drain length", run, DEPTH);
    check(expQ.size() == 0, "R4 dropped samples not delivered", expQ.size(), 0);

    // Back-to-back burst against the slower reader: drops while draining (R5, R2, R8)
    @(negedge srcClk);
    accBase  = accepted;
    dropBase = dropped;
    for (int i = 0; i < 120; i++) push(WIDTH'(i * 7 + 3));
    repeat (3) @(negedge srcClk);
    check(dropped - dropBase > 0, "R5 overrun under sustained burst", dropped - dropBase, 1);
    check((accepted - accBase) + (dropped - dropBase) == 120, "R5 every offer judged",
          (accepted - accBase) + (dropped - dropBase), 120);
    repeat (60) @(negedge dstClk);
    check(expQ.size() == 0, "R8 burst fully delivered across domains", expQ.size(), 0);

    // Gapped traffic: reader keeps up, nothing may drop (R5, R2)
    dropBase = dropped;
    lfsr = 16'hACE1;
    for (int i = 0; i < 100; i++) begin
      push(WIDTH'(lfsr[7:0]));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      repeat (1 + int'(lfsr[1:0] % 3)) @(posedge srcClk);
      #1;
    end
    repeat (3) @(negedge srcClk);
    check(dropped == dropBase, "R5 no overrun at sustainable rate", dropped - dropBase, 0);
    repeat (30) @(negedge dstClk);
    check(expQ.size() == 0, "R2 queue drained", expQ.size(), 0);
    check(delivered == accepted, "R2 each accepted sample once", delivered, accepted);

    finished = 1'b1;
    finishRun();
  end

endmodule